// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the word offset (the two least significant address bits) for a four-beat burst on a synchronous, SRAM-style bus. When an address strobe is accepted while the part is selected, it captures the whole incoming address. The upper bits are held in a register and the low two bits become the starting offset of the burst. Each later cycle with no strobe and with the advance input asserted moves the offset one place along the burst order. The burst wraps after four beats.

A static order input picks the burst order. When it is low, the order is a plain modulo-4 increment. When it is high, the order XORs the starting offset with the beat number. Two strobes load the sequencer: one from the processor and one from the cache controller. The processor strobe is only seen while the first chip enable is active. A strobe seen while any chip enable is inactive is a deselect cycle and ends the burst. A valid flag shows whether a burst is open. Advance and hold cycles act only while that flag is set.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset, `burst_valid` is 0, `word_off` is 00 and `upper_addr` is all zeros.
- R2: An accepted strobe with all three enables active (`sel1_n`=0, `sel2`=1, `sel3_n`=0) loads the sequencer. In the next cycle, `word_off` equals the loaded `addr_in[1:0]`, `upper_addr` equals `addr_in[ADDR_W-1:2]` and `burst_valid` is 1. A strobe is accepted when either `cpu_ads_n` is 0 with `sel1_n` 0, or `ctl_ads_n` is 0. When both strobes are low, they give a single load.
- R3: While `sel1_n` is 1, a low `cpu_ads_n` is ignored if `ctl_ads_n` is high. The cycle then behaves as a no-strobe cycle, so an open burst advances or holds according to `adv_n`.
- R4: An accepted strobe while any enable is inactive is a deselect cycle. In the next cycle `burst_valid` is 0, while `word_off` and `upper_addr` keep their values.
- R5: With `order_sel`=0, each no-strobe cycle with `adv_n`=0 during an open burst gives `word_off` = (start + k) mod 4 after k steps.
- R6: With `order_sel`=1, each advancing cycle gives `word_off` = start XOR (k mod 4) after k steps.
- R7: After four advancing steps, `word_off` returns to the start offset, and later steps repeat the same order.
- R8: During an open burst, a no-strobe cycle with `adv_n`=1 leaves `word_off` unchanged.
- R9: While `burst_valid` is 0, no-strobe cycles have no effect on `word_off` or `burst_valid`, whatever the value of `adv_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| order_sel | input | 1 | Static burst order: 0 linear, 1 XOR-interleaved |
| cpu_ads_n | input | 1 | Processor address strobe, active low |
| ctl_ads_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance, active low |
| sel1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| addr_in | input | ADDR_W | Address presented with a strobe |
| upper_addr | output | ADDR_W-2 | Registered upper address bits |
| word_off | output | 2 | Current burst word offset |
| burst_valid | output | 1 | A burst is open |

## Verification
Several kinds of internal fault show at the ports. A corrupted start register or beat counter shows on `word_off` at the very next advance, or at once if the fault is in the register itself. A wrong order mapping is hidden at beat zero and first appears at the second beat, so every start offset is swept in both orders over at least five steps, which covers the wrap. A stuck or mis-cleared valid flag shows up when the offset moves or stays still after a deselect or an ignored strobe, one cycle after the stimulus.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_t;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_LOAD,
        CYC_DESEL,
        CYC_STEP,
        CYC_HOLD
    } cyc_kind_t;

    // Offset presented for a given start and beat number.
    function automatic beat_t map_offset(burst_order_t ord, beat_t start, beat_t beat);
        if (ord == ORD_INTERLEAVE)
            return start ^ beat;
        return beat_t'(start + beat);
    endfunction

endpackage

// File: rtl/burst_cycle_decode.sv
module burst_cycle_decode
    import burst_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cpu_ads_n,
    input  logic      ctl_ads_n,
    input  logic      adv_n,
    input  logic      sel1_n,
    input  logic      sel2,
    input  logic      sel3_n,
    input  logic      open_q,
    output cyc_kind_t kind
);

    logic cpu_seen;
    logic strobe_seen;
    logic all_sel;

    always_comb begin
        cpu_seen    = !cpu_ads_n && !sel1_n;
        strobe_seen = cpu_seen || !ctl_ads_n;
        all_sel     = !sel1_n && sel2 && !sel3_n;
        if (strobe_seen)
            kind = all_sel ? CYC_LOAD : CYC_DESEL;
        else if (!open_q)
            kind = CYC_IDLE;
        else if (!adv_n)
            kind = CYC_STEP;
        else
            kind = CYC_HOLD;
    end

    // R2
    cpu_strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ads_n && !sel1_n && sel2 && !sel3_n) |-> (kind == CYC_LOAD));

endmodule

// File: rtl/burst_order_counter.sv
module burst_order_counter
    import burst_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  cyc_kind_t    kind,
    input  burst_order_t order,
    input  beat_t        start_in,
    output beat_t        offset
);

    beat_t start_q;
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            beat_q  <= '0;
        end else begin
            unique case (kind)
                CYC_LOAD: begin
                    start_q <= start_in;
                    beat_q  <= '0;
                end
                CYC_STEP: beat_q <= beat_q + beat_t'(1);
                default:  ;
            endcase
        end
    end

    assign offset = map_offset(order, start_q, beat_q);

    // R2
    load_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_LOAD) |=> (offset == $past(start_in)));

    // R8
    hold_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_HOLD || kind == CYC_IDLE || kind == CYC_DESEL) |=> $stable(offset));

endmodule

// File: rtl/burst_addr_hold.sv
module burst_addr_hold #(
    parameter int UP_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  burst_seq_pkg::cyc_kind_t kind,
    input  logic [UP_W-1:0]     upper_in,
    output logic [UP_W-1:0]     upper_q,
    output logic                open_q
);
    import burst_seq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            open_q  <= 1'b0;
        end else if (kind == CYC_LOAD) begin
            upper_q <= upper_in;
            open_q  <= 1'b1;
        end else if (kind == CYC_DESEL) begin
            open_q  <= 1'b0;
        end
    end

    // R4
    desel_close_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_DESEL) |=> (!open_q && $stable(upper_q)));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              order_sel,
    input  logic              cpu_ads_n,
    input  logic              ctl_ads_n,
    input  logic              adv_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-3:0] upper_addr,
    output logic [1:0]        word_off,
    output logic              burst_valid
);
    import burst_seq_pkg::*;

    localparam int UP_W = ADDR_W - BEAT_W;

    cyc_kind_t    kind;
    burst_order_t order;
    beat_t        offset;
    logic         open_q;

    assign order = burst_order_t'(order_sel);

    burst_cycle_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .cpu_ads_n (cpu_ads_n),
        .ctl_ads_n (ctl_ads_n),
        .adv_n     (adv_n),
        .sel1_n    (sel1_n),
        .sel2      (sel2),
        .sel3_n    (sel3_n),
        .open_q    (open_q),
        .kind      (kind)
    );

    burst_order_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .order    (order),
        .start_in (addr_in[BEAT_W-1:0]),
        .offset   (offset)
    );

    burst_addr_hold #(.UP_W(UP_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .upper_in (addr_in[ADDR_W-1:BEAT_W]),
        .upper_q  (upper_addr),
        .open_q   (open_q)
    );

    assign word_off    = offset;
    assign burst_valid = open_q;

    // R3
    cpu_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ads_n && sel1_n && ctl_ads_n && open_q && adv_n) |=> ($stable(word_off) && burst_valid));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ads_n && ctl_ads_n && open_q && !adv_n && !order_sel) |=> (word_off == $past(word_off) + 2'd1));

    // R9
    idle_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ads_n && ctl_ads_n && !open_q) |=> ($stable(word_off) && !burst_valid));

endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst;
    logic              order_sel;
    logic              cpu_ads_n, ctl_ads_n, adv_n;
    logic              sel1_n, sel2, sel3_n;
    logic [ADDR_W-1:0] addr_in;
    logic [ADDR_W-3:0] upper_addr;
    logic [1:0]        word_off;
    logic              burst_valid;

    int vectors = 0;
    int errors  = 0;

    // model state
    logic              m_valid = 1'b0;
    logic [1:0]        m_start = 2'd0;
    logic [1:0]        m_beat  = 2'd0;
    logic [ADDR_W-3:0] m_upper = '0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .order_sel(order_sel),
        .cpu_ads_n(cpu_ads_n), .ctl_ads_n(ctl_ads_n), .adv_n(adv_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .addr_in(addr_in), .upper_addr(upper_addr),
        .word_off(word_off), .burst_valid(burst_valid)
    );

    function automatic logic [1:0] exp_off();
        if (order_sel) return m_start ^ m_beat;
        return m_start + m_beat;
    endfunction

    task automatic check_all(input string tag);
        logic [1:0] e;
        e = exp_off();
        vectors++;
        if (word_off !== e || burst_valid !== m_valid || upper_addr !== m_upper) begin
            errors++;
            $display("FAIL %s: off=%0d valid=%0d upper=%0h expected off=%0d valid=%0d upper=%0h",
                     tag, word_off, burst_valid, upper_addr, e, m_valid, m_upper);
        end
    endtask

    task automatic cyc(input logic p, input logic c, input logic a,
                       input logic e1, input logic e2, input logic e3,
                       input logic [ADDR_W-1:0] ad, input string tag);
        logic strobe, sel;
        @(negedge clk);
        cpu_ads_n = p; ctl_ads_n = c; adv_n = a;
        sel1_n = e1; sel2 = e2; sel3_n = e3; addr_in = ad;
        @(posedge clk);
        strobe = (!p && !e1) || !c;
        sel    = !e1 && e2 && !e3;
        if (strobe) begin
            if (sel) begin
                m_valid = 1'b1; m_start = ad[1:0]; m_beat = 2'd0;
                m_upper = ad[ADDR_W-1:2];
            end else begin
                m_valid = 1'b0;
            end
        end else if (m_valid && !a) begin
            m_beat = m_beat + 2'd1;
        end
        #1;
        check_all(tag);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; order_sel = 1'b0;
        cpu_ads_n = 1'b1; ctl_ads_n = 1'b1; adv_n = 1'b1;
        sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1; addr_in = '0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst = 1'b0;

        for (int m = 0; m < 2; m++) begin
            order_sel = logic'(m);
            for (int s = 0; s < 4; s++) begin
                string st;
                logic [ADDR_W-1:0] ad;
                st = (m == 1) ? "R6" : "R5";
                ad = {10'((m * 4 + s) * 37 + 1), 2'(s)};
                // load via processor (even) or controller (odd)
                if (s % 2 == 0) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, ad, "R2");
                else            cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ad, "R2");
                for (int k = 1; k <= 3; k++)
                    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, st);
                cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, "R7");
                cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, "R7");
                cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '1, "R8");
                cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, "R8");
                // processor strobe with enable 1 off: ignored
                cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '1, "R3");
                cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R3");
                // deselect with one enable inactive, chosen by start
                case (s)
                    0: cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '1, "R4");
                    1: cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '1, "R4");
                    2: cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '1, "R4");
                    default: cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '1, "R4");
                endcase
                cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R9");
                cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R9");
                cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R9");
            end
        end

        // both strobes low with all enables active: one load
        order_sel = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'hA5E, "R2");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R6");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R6");
        // reload mid-burst
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h3C1, "R2");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R6");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule